// File: doc/BRIEF.md
# Serial Frame Parity and CRC Checker

This block sits behind a byte-oriented serial receiver and checks what that receiver hands over. For every received character it checks the received parity bit against the selected parity mode: none, odd or even. Over a whole frame it keeps a running 16-bit cyclic redundancy check. Each data byte is folded into the check in a single clock.

A frame opens with a start strobe, which presets the CRC register to all ones. It closes with an end strobe. One cycle after the end strobe the block reports whether the CRC residue is zero and whether the frame was shorter than the minimum length. The trailing two check bytes are sent low byte first, so a correct frame leaves zero in the register. A transmitter can use the same block: it feeds its payload bytes and then reads the running value to obtain the check field.

Top module: `frame_check`

## Requirements
- R1: `par_mode` encodes 00 = no parity, 01 = odd, 10 = even, 11 = no parity. With no parity selected, `par_err` never rises, whatever the value of `rx_par`.
- R2: Under even parity, a byte is in error when the count of ones in `rx_byte` plus `rx_par` is odd. For example, data 0xCE (five ones) with `rx_par`=1 is accepted.
- R3: Under odd parity, a byte is in error when the count of ones in `rx_byte` plus `rx_par` is even. For example, data 0xCE with `rx_par`=0 is accepted.
- R4: `par_err` takes its new value in the cycle after a `byte_vld` strobe and holds it until the next strobe. A `frame_sof` without `byte_vld` clears it.
- R5: Reset, and a `frame_sof` without `byte_vld`, both set `crc_value` to 0xFFFF.
- R6: Each `byte_vld` strobe absorbs one byte in one clock. The byte is XORed into the low 8 bits of the register, followed by 8 right shifts; a shift XORs 0xA001 whenever the bit shifted out is 1. Without a strobe or start, `crc_value` does not change.
- R7: After the data bytes 01 03 00 00 00 01, `crc_value` reads 0x0A84, which is the check field a transmitter appends low byte first.
- R8: In the cycle after `frame_eof`, `frame_crc_ok` is 1 exactly when the register, having absorbed all bytes including the two check bytes, holds 0x0000. The value holds until the next end strobe.
- R9: In the cycle after `frame_eof`, `frame_short` is 1 exactly when fewer than 6 bytes were received since the frame start.
- R10: A `frame_eof` in the same cycle as `byte_vld` counts that byte. A `frame_sof` in the same cycle as `byte_vld` starts a new frame that has that byte as its first byte.
- R11: `frame_done` is a single-cycle pulse in the cycle after each `frame_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Received data byte |
| rx_par | input | 1 | Received parity bit |
| byte_vld | input | 1 | Byte strobe, one cycle per character |
| frame_sof | input | 1 | Frame start: presets the CRC and the length count |
| frame_eof | input | 1 | Frame end: requests the frame verdict |
| par_mode | input | 2 | Parity mode selection |
| par_err | output | 1 | Parity error of the last byte |
| crc_value | output | 16 | Running CRC register |
| frame_done | output | 1 | Verdict valid pulse |
| frame_crc_ok | output | 1 | CRC residue was zero |
| frame_short | output | 1 | Frame was below minimum length |

## Verification
The bench targets the parity polarity for both modes, including the worked 0xCE case. A checker with even and odd swapped would flag exactly the accepted bytes. The bench feeds a frame whose known check value is 0x0A84; a wrong preset, wrong shift direction or wrong constant gives a different value, and a byte-order mix-up makes good frames fail. The bench also exercises frames of exactly five and exactly six bytes, where an off-by-one length threshold flips the short flag. It also exercises end and start strobes that coincide with a byte strobe, where a design that ignores the coincident byte reports a wrong residue.

// File: rtl/frmchk_pkg.sv
// Shared types and constants for the frame checker.
package frmchk_pkg;
    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_EVEN  = 2'b10,
        PAR_NONE2 = 2'b11
    } par_mode_e;
endpackage

// File: rtl/frmchk_parity.sv
// Per-character parity checker.
// Assumes one strobe per character. Mode codes other than odd/even disable checking.
module frmchk_parity #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic              clr,
    input  logic [DATA_W-1:0] data,
    input  logic              pbit,
    input  logic [1:0]        mode,
    output logic              err
);
    import frmchk_pkg::*;

    logic ones_odd;
    logic bad;
    logic err_q;

    // Decide whether the received character breaks the selected parity rule.
    always_comb begin
        ones_odd = ^{data, pbit};
        case (mode)
            PAR_EVEN: bad = ones_odd;
            PAR_ODD:  bad = ~ones_odd;
            default:  bad = 1'b0;
        endcase
    end

    // Latch the verdict per character; a frame start alone clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   err_q <= 1'b0;
        else if (vld) err_q <= bad;
        else if (clr) err_q <= 1'b0;
    end

    assign err = err_q;
endmodule

// File: rtl/frmchk_crc8.sv
// One byte of a reflected CRC, with the eight bit steps unrolled.
// Purely combinational. Assumes the LSB-first bit order.
module frmchk_crc8 #(
    parameter int          CRC_W  = 16,
    parameter int          DATA_W = 8,
    parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] stg [0:DATA_W];

    // Fold the byte into the low end of the register.
    assign stg[0] = crc_in ^ {{(CRC_W-DATA_W){1'b0}}, data};

    // One shift toward the LSB per stage, conditional XOR with the constant.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign stg[i+1] = stg[i][0] ? ((stg[i] >> 1) ^ POLY) : (stg[i] >> 1);
    end

    assign crc_out = stg[DATA_W];
endmodule

// File: rtl/frmchk_len.sv
// Saturating frame length counter. It gives the short-frame verdict that
// would apply if the frame ended this cycle.
module frmchk_len #(
    parameter int MIN_BYTES = 6,
    localparam int CNT_W = $clog2(MIN_BYTES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld,
    input  logic sof,
    output logic short_nxt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_nxt;

    // Next count: restart on sof, saturate at the minimum length.
    always_comb begin
        base = sof ? '0 : cnt_q;
        if (vld && (base != CNT_W'(MIN_BYTES))) cnt_nxt = base + 1'b1;
        else                                    cnt_nxt = base;
        short_nxt = (cnt_nxt < CNT_W'(MIN_BYTES));
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/frame_check.sv
// Frame parity and CRC checker top. It checks parity per character and the
// CRC residue over each frame, and reports the verdict the cycle after the end strobe.
// Assumes strobes come from a byte receiver with framing already resolved.
module frame_check #(
    parameter int               DATA_W    = 8,
    parameter int               CRC_W     = 16,
    parameter logic [CRC_W-1:0] POLY      = 16'hA001,
    parameter logic [CRC_W-1:0] INIT      = 16'hFFFF,
    parameter int               MIN_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_par,
    input  logic              byte_vld,
    input  logic              frame_sof,
    input  logic              frame_eof,
    input  logic [1:0]        par_mode,
    output logic              par_err,
    output logic [CRC_W-1:0]  crc_value,
    output logic              frame_done,
    output logic              frame_crc_ok,
    output logic              frame_short
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;
    logic [CRC_W-1:0] crc_step;
    logic [CRC_W-1:0] crc_nxt;
    logic             short_nxt;
    logic             done_q;
    logic             ok_q;
    logic             short_q;

    frmchk_parity #(.DATA_W(DATA_W)) u_par (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (byte_vld),
        .clr  (frame_sof),
        .data (rx_byte),
        .pbit (rx_par),
        .mode (par_mode),
        .err  (par_err)
    );

    frmchk_crc8 #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_crc8 (
        .crc_in (crc_base),
        .data   (rx_byte),
        .crc_out(crc_step)
    );

    frmchk_len #(.MIN_BYTES(MIN_BYTES)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (byte_vld),
        .sof      (frame_sof),
        .short_nxt(short_nxt)
    );

    // Select the register value that applies after this cycle's strobes.
    always_comb begin
        crc_base = frame_sof ? INIT : crc_q;
        crc_nxt  = byte_vld ? crc_step : crc_base;
    end

    // Running CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_nxt;
    end

    // Capture the frame verdict on the end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ok_q    <= 1'b0;
            short_q <= 1'b0;
        end else begin
            done_q <= frame_eof;
            if (frame_eof) begin
                ok_q    <= (crc_nxt == '0);
                short_q <= short_nxt;
            end
        end
    end

    assign crc_value    = crc_q;
    assign frame_done   = done_q;
    assign frame_crc_ok = ok_q;
    assign frame_short  = short_q;
endmodule

// File: rtl/frame_check_sva.sv
// Assertion checker for frame_check, attached by bind below.
module frame_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  rx_byte,
    input logic        rx_par,
    input logic        byte_vld,
    input logic        frame_sof,
    input logic        frame_eof,
    input logic [1:0]  par_mode,
    input logic        par_err,
    input logic [15:0] crc_value,
    input logic        frame_done
);
    // R1: no parity mode never flags
    a_r1_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && (par_mode == 2'b00 || par_mode == 2'b11)) |=> !par_err);

    // R2: even parity verdict
    a_r2_even_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && par_mode == 2'b10) |=> (par_err == ^{$past(rx_byte), $past(rx_par)}));

    // R4: flag holds without a strobe or start
    a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !frame_sof) |=> $stable(par_err));

    // R5: start alone presets the register
    a_r5_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sof && !byte_vld) |=> (crc_value == 16'hFFFF));

    // R6: register idle without strobes
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !frame_sof) |=> $stable(crc_value));

    // R11: verdict pulse follows each end strobe
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_eof |=> frame_done);

    // R11: no pulse without an end strobe
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_eof |=> !frame_done);
endmodule

bind frame_check frame_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .rx_par    (rx_par),
    .byte_vld  (byte_vld),
    .frame_sof (frame_sof),
    .frame_eof (frame_eof),
    .par_mode  (par_mode),
    .par_err   (par_err),
    .crc_value (crc_value),
    .frame_done(frame_done)
);

// File: tb/frame_check_tb_top.sv
module frame_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_par = 1'b0;
    logic        byte_vld = 1'b0;
    logic        frame_sof = 1'b0;
    logic        frame_eof = 1'b0;
    logic [1:0]  par_mode = 2'b00;
    logic        par_err;
    logic [15:0] crc_value;
    logic        frame_done;
    logic        frame_crc_ok;
    logic        frame_short;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    frame_check dut_i (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_par(rx_par),
        .byte_vld(byte_vld), .frame_sof(frame_sof), .frame_eof(frame_eof),
        .par_mode(par_mode), .par_err(par_err), .crc_value(crc_value),
        .frame_done(frame_done), .frame_crc_ok(frame_crc_ok), .frame_short(frame_short)
    );

    // {mode[1:0], data[7:0], pbit, expected error}
    localparam int NV = 12;
    localparam logic [11:0] VEC [NV] = '{
        {2'b10, 8'hCE, 1'b1, 1'b0},
        {2'b10, 8'hCE, 1'b0, 1'b1},
        {2'b01, 8'hCE, 1'b0, 1'b0},
        {2'b01, 8'hCE, 1'b1, 1'b1},
        {2'b00, 8'hCE, 1'b0, 1'b0},
        {2'b00, 8'hCE, 1'b1, 1'b0},
        {2'b11, 8'h01, 1'b0, 1'b0},
        {2'b10, 8'h00, 1'b0, 1'b0},
        {2'b01, 8'h00, 1'b0, 1'b1},
        {2'b01, 8'hFF, 1'b1, 1'b0},
        {2'b10, 8'hFF, 1'b1, 1'b1},
        {2'b10, 8'h80, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
        logic [15:0] r = 16'hFFFF;
        foreach (b[i]) begin
            r = r ^ {8'h00, b[i]};
            for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        end
        return r;
    endfunction

    // Drive bytes, one per cycle; optionally start and/or end strobe on first/last.
    task automatic send_bytes(input logic [7:0] b[$], input bit sof_first, input bit eof_last);
        foreach (b[i]) begin
            @(negedge clk);
            byte_vld  = 1'b1;
            rx_byte   = b[i];
            frame_sof = sof_first && (i == 0);
            frame_eof = eof_last && (i == b.size() - 1);
        end
        @(negedge clk);
        byte_vld = 1'b0; frame_sof = 1'b0; frame_eof = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk); frame_eof = 1'b1;
        @(negedge clk); frame_eof = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] fr[$];
        logic [15:0] c;
        repeat (3) @(negedge clk);
        // Reset state (R5, R4, R11)
        chk("R5 reset crc", crc_value, 16'hFFFF);
        chk("R4 reset par_err", {15'd0, par_err}, 16'd0);
        chk("R11 reset done", {15'd0, frame_done}, 16'd0);
        rst_n = 1'b1;

        // Parity vector table (R1 R2 R3 R4)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            par_mode = VEC[i][11:10]; rx_byte = VEC[i][9:2]; rx_par = VEC[i][1]; byte_vld = 1'b1;
            @(negedge clk);
            byte_vld = 1'b0;
            case (VEC[i][11:10])
                2'b10:   chk($sformatf("R2 even vec %0d", i), {15'd0, par_err}, {15'd0, VEC[i][0]});
                2'b01:   chk($sformatf("R3 odd vec %0d", i), {15'd0, par_err}, {15'd0, VEC[i][0]});
                default: chk($sformatf("R1 none vec %0d", i), {15'd0, par_err}, {15'd0, VEC[i][0]});
            endcase
        end

        // R4: hold then clear by start alone
        @(negedge clk); par_mode = 2'b10; rx_byte = 8'h01; rx_par = 1'b0; byte_vld = 1'b1;
        @(negedge clk); byte_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 par_err held", {15'd0, par_err}, 16'd1);
        frame_sof = 1'b1;
        @(negedge clk); frame_sof = 1'b0;
        chk("R4 par_err cleared by sof", {15'd0, par_err}, 16'd0);
        chk("R5 sof preset", crc_value, 16'hFFFF);
        par_mode = 2'b00;

        // R7: transmitter value for known payload; R6 idle stability
        fr = '{8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h01};
        send_bytes(fr, 1'b1, 1'b0);
        chk("R7 known payload crc", crc_value, 16'h0A84);
        chk("R6 payload crc vs model", crc_value, ref_crc(fr));
        repeat (4) @(negedge clk);
        chk("R6 crc stable when idle", crc_value, 16'h0A84);

        // R8 R9 R11: good frame, check field low byte first, separate end strobe
        c = ref_crc(fr);
        send_bytes('{c[7:0], c[15:8]}, 1'b0, 1'b0);
        end_frame();
        chk("R11 done pulse", {15'd0, frame_done}, 16'd1);
        chk("R8 good frame ok", {15'd0, frame_crc_ok}, 16'd1);
        chk("R9 long frame not short", {15'd0, frame_short}, 16'd0);
        @(negedge clk);
        chk("R11 done single cycle", {15'd0, frame_done}, 16'd0);
        chk("R8 ok holds", {15'd0, frame_crc_ok}, 16'd1);

        // R8: corrupted byte
        fr = '{8'h11, 8'h06, 8'h00, 8'h01, 8'h00, 8'h17};
        c = ref_crc(fr);
        fr.push_back(c[7:0]); fr.push_back(c[15:8] ^ 8'h01);
        send_bytes(fr, 1'b1, 1'b1);
        chk("R8 bad frame rejected", {15'd0, frame_crc_ok}, 16'd0);

        // R10: end strobe on the last byte; start strobe coinciding with first byte
        fr = '{8'h11, 8'h06, 8'h00, 8'h01, 8'h00, 8'h17};
        c = ref_crc(fr);
        fr.push_back(c[7:0]); fr.push_back(c[15:8]);
        send_bytes(fr, 1'b1, 1'b1);
        chk("R10 eof with last byte ok", {15'd0, frame_crc_ok}, 16'd1);
        chk("R10 done with last byte", {15'd0, frame_done}, 16'd1);

        // R9: five bytes short, six bytes not short (6 = 4 data + 2 check)
        fr = '{8'hAA, 8'h55, 8'h00};
        c = ref_crc(fr);
        fr.push_back(c[7:0]); fr.push_back(c[15:8]);
        send_bytes(fr, 1'b1, 1'b1);
        chk("R9 five bytes short", {15'd0, frame_short}, 16'd1);
        chk("R8 five byte residue ok", {15'd0, frame_crc_ok}, 16'd1);
        fr = '{8'hAA, 8'h55, 8'h00, 8'h7E};
        c = ref_crc(fr);
        fr.push_back(c[7:0]); fr.push_back(c[15:8]);
        send_bytes(fr, 1'b1, 1'b1);
        chk("R9 six bytes not short", {15'd0, frame_short}, 16'd0);
        chk("R8 six byte ok", {15'd0, frame_crc_ok}, 16'd1);

        // R9: empty frame
        @(negedge clk); frame_sof = 1'b1;
        @(negedge clk); frame_sof = 1'b0;
        end_frame();
        chk("R9 empty frame short", {15'd0, frame_short}, 16'd1);

        // R6: byte data with no strobe is ignored
        @(negedge clk); rx_byte = 8'h5A;
        @(negedge clk);
        chk("R6 unstrobed byte ignored", crc_value, 16'hFFFF);

        finish_run();
    end
endmodule